// File: doc/BRIEF.md
# USB Host Root Port Suspend and Resume Controller

This block sequences a full-speed USB host root port into and out of suspend. Software asks for suspend with a one-cycle request, and from then on frame-start generation is held off. The block leaves suspend in one of two ways. The attached device can signal remote wakeup by holding the line in K-state. Software can also raise the port's resume control bit.

When the block recognises remote wakeup, it sets a wakeup interrupt flag. It also raises the resume control bit by itself, and that bit drives K-state resume signalling onto the line. Software times the resume window and then writes the resume bit to zero. The block then emits an end-of-resume pattern for a programmable number of cycles, requests line idle for one cycle, and re-enables frame-start generation. The line-state request outputs go to a transceiver interface that is not part of this block.

Top module: `usb_port_suspend_ctl`

## Requirements
- R1: After reset the port is active: `sof_en`=1, and `suspended`, `resume_bit`, `wake_irq`, `drive_k`, `drive_eor` and `drive_idle` are all 0.
- R2: `suspend_req` while active makes `suspended`=1 and `sof_en`=0 from the next cycle. `suspend_req` in any other phase has no effect.
- R3: While suspended, `line_k`=1 sampled on WAKE_CYCLES consecutive edges sets `wake_irq`=1 and `resume_bit`=1 on the last of those edges. A shorter K run, broken by `line_k`=0, sets neither, and the count starts again.
- R4: `drive_k` is 1 exactly while `resume_bit` is 1.
- R5: `wake_irq` is write-one-to-clear. `wake_wr`=1 with `wake_wdata`=1 clears it. With `wake_wdata`=0 it is unchanged. A wakeup detection in the same cycle as a clear leaves the flag at 1.
- R6: `resume_wr`=1 with `resume_wdata`=1 while suspended sets `resume_bit`. Writing 1 while the port is active, or in the end-of-resume or idle phase, has no effect.
- R7: A write of 0 to the resume bit while it is 1 ends resume. The block then drives `drive_eor`=1 for EOR_CYCLES cycles, then `drive_idle`=1 for one cycle, and then sets `sof_en`=1.
- R8: `sof_en` is 0 whenever the port is suspended, resuming, in end-of-resume or in idle. At most one of `drive_k`, `drive_eor` and `drive_idle` is 1 at any time.
- R9: `line_k` has no effect while the port is not suspended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| suspend_req | input | 1 | One-cycle request to suspend the port |
| resume_wr | input | 1 | Write strobe for the resume control bit |
| resume_wdata | input | 1 | Value written to the resume control bit |
| wake_wr | input | 1 | Write strobe for the wakeup interrupt flag |
| wake_wdata | input | 1 | Write data for the flag; 1 clears it |
| line_k | input | 1 | Bus line is in K-state |
| resume_bit | output | 1 | Resume control bit readback |
| suspended | output | 1 | Port is in the suspended state (including resume) |
| wake_irq | output | 1 | Remote-wakeup interrupt flag |
| drive_k | output | 1 | Request K-state resume signalling |
| drive_eor | output | 1 | Request end-of-resume pattern |
| drive_idle | output | 1 | Request line idle |
| sof_en | output | 1 | Frame-start generation enable |

## Verification
The bench aims at the K-run threshold. A run one cycle short must be ignored, and a run of exactly WAKE_CYCLES must trigger. An off-by-one counter would wake early or late by a cycle, and a counter that does not clear on a broken run would wake on two short glitches. It also aims at a flag clear that lands on the detection edge, which a design giving the clear priority would lose. The bench checks writes of 1 to the resume bit and suspend requests outside their phases, which a loose decoder would accept. It also counts the exact length of the end-of-resume and idle phases, which a design that restarts frame generation too soon would cut short.

// File: rtl/usb_port_suspend_ctl.sv
module usb_port_suspend_ctl #(
  parameter int WAKE_CYCLES = 16,
  parameter int EOR_CYCLES  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic suspend_req,
  input  logic resume_wr,
  input  logic resume_wdata,
  input  logic wake_wr,
  input  logic wake_wdata,
  input  logic line_k,
  output logic resume_bit,
  output logic suspended,
  output logic wake_irq,
  output logic drive_k,
  output logic drive_eor,
  output logic drive_idle,
  output logic sof_en
);
  localparam int KW = $clog2(WAKE_CYCLES + 1);
  localparam int EW = $clog2(EOR_CYCLES + 1);
  localparam logic [KW-1:0] K_LAST = KW'(WAKE_CYCLES - 1);
  localparam logic [EW-1:0] E_LAST = EW'(EOR_CYCLES - 1);

  typedef enum logic [2:0] {P_ACTIVE, P_SUSP, P_RESUME, P_EOR, P_IDLE} phase_t;

  phase_t          phase;
  logic [KW-1:0]   kcnt;
  logic [EW-1:0]   ecnt;
  logic            wake_hit;

  assign wake_hit   = (phase == P_SUSP) && line_k && (kcnt == K_LAST);

  assign resume_bit = (phase == P_RESUME);
  assign suspended  = (phase == P_SUSP) || (phase == P_RESUME);
  assign drive_k    = resume_bit;
  assign drive_eor  = (phase == P_EOR);
  assign drive_idle = (phase == P_IDLE);
  assign sof_en     = (phase == P_ACTIVE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase    <= P_ACTIVE;
      kcnt     <= '0;
      ecnt     <= '0;
      wake_irq <= 1'b0;
    end else begin
      kcnt <= ((phase == P_SUSP) && line_k && !wake_hit) ? kcnt + 1'b1 : '0;
      ecnt <= (phase == P_EOR) ? ecnt + 1'b1 : '0;

      if (wake_hit)
        wake_irq <= 1'b1;
      else if (wake_wr && wake_wdata)
        wake_irq <= 1'b0;

      unique case (phase)
        P_ACTIVE: if (suspend_req) phase <= P_SUSP;
        P_SUSP:   if (wake_hit || (resume_wr && resume_wdata)) phase <= P_RESUME;
        P_RESUME: if (resume_wr && !resume_wdata) phase <= P_EOR;
        P_EOR:    if (ecnt == E_LAST) phase <= P_IDLE;
        P_IDLE:   phase <= P_ACTIVE;
        default:  phase <= P_ACTIVE;
      endcase
    end
  end
endmodule

// File: rtl/usb_port_suspend_ctl_chk.sv
module usb_port_suspend_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic suspend_req,
  input logic wake_wr,
  input logic wake_wdata,
  input logic resume_bit,
  input logic suspended,
  input logic wake_irq,
  input logic drive_k,
  input logic drive_eor,
  input logic drive_idle,
  input logic sof_en
);
  a_r2_suspend_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_en && suspend_req) |=> (suspended && !sof_en));

  a_r3_irq_brings_resume: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> resume_bit);

  a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !(wake_wr && wake_wdata)) |=> wake_irq);

  a_r6_resume_from_suspend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(resume_bit) |-> !$past(sof_en));

  a_r7_eor_follows_resume: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(resume_bit) |-> drive_eor);

  a_r7_idle_before_sof: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sof_en) |-> $past(drive_idle));

  a_r8_sof_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (suspended || drive_k || drive_eor || drive_idle) |-> !sof_en);

  a_r8_one_drive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drive_k, drive_eor, drive_idle}));
endmodule

bind usb_port_suspend_ctl usb_port_suspend_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .suspend_req(suspend_req),
  .wake_wr(wake_wr), .wake_wdata(wake_wdata),
  .resume_bit(resume_bit), .suspended(suspended), .wake_irq(wake_irq),
  .drive_k(drive_k), .drive_eor(drive_eor), .drive_idle(drive_idle),
  .sof_en(sof_en)
);

// File: tb/test_usb_port_suspend_ctl.sv
module test_usb_port_suspend_ctl;
  localparam int WAKE = 6;
  localparam int EOR  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic suspend_req = 0, resume_wr = 0, resume_wdata = 0;
  logic wake_wr = 0, wake_wdata = 0, line_k = 0;
  logic resume_bit, suspended, wake_irq, drive_k, drive_eor, drive_idle, sof_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  usb_port_suspend_ctl #(.WAKE_CYCLES(WAKE), .EOR_CYCLES(EOR)) i_usb_port_suspend_ctl (
    .clk(clk), .rst_n(rst_n), .suspend_req(suspend_req),
    .resume_wr(resume_wr), .resume_wdata(resume_wdata),
    .wake_wr(wake_wr), .wake_wdata(wake_wdata), .line_k(line_k),
    .resume_bit(resume_bit), .suspended(suspended), .wake_irq(wake_irq),
    .drive_k(drive_k), .drive_eor(drive_eor), .drive_idle(drive_idle),
    .sof_en(sof_en)
  );

  // Reference model: phase 0 active, 1 suspended, 2 resuming, 3 end-of-resume, 4 idle
  int m_ph = 0;
  int m_krun = 0;
  int m_eor = 0;
  bit m_irq = 0;

  always @(posedge clk) begin
    bit hit;
    cycles++;
    if (!rst_n) begin
      m_ph = 0; m_krun = 0; m_eor = 0; m_irq = 0;
    end else begin
      hit = 0;
      if (m_ph == 1 && line_k) begin
        m_krun++;
        if (m_krun >= WAKE) begin hit = 1; m_krun = 0; end
      end else m_krun = 0;
      if (hit) m_irq = 1;
      else if (wake_wr && wake_wdata) m_irq = 0;
      case (m_ph)
        0: if (suspend_req) m_ph = 1;
        1: if (hit || (resume_wr && resume_wdata)) m_ph = 2;
        2: if (resume_wr && !resume_wdata) begin m_ph = 3; m_eor = 0; end
        3: begin m_eor++; if (m_eor == EOR) m_ph = 4; end
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, cycles, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(sof_en,     m_ph == 0, "R8", "sof_en");
      chk(suspended,  m_ph == 1 || m_ph == 2, "R2", "suspended");
      chk(resume_bit, m_ph == 2, "R6", "resume_bit");
      chk(drive_k,    m_ph == 2, "R4", "drive_k");
      chk(drive_eor,  m_ph == 3, "R7", "drive_eor");
      chk(drive_idle, m_ph == 4, "R7", "drive_idle");
      chk(wake_irq,   m_irq, "R5", "wake_irq");
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_suspend();
    suspend_req = 1; tick(1); suspend_req = 0;
  endtask

  task automatic write_resume(input bit v);
    resume_wr = 1; resume_wdata = v; tick(1); resume_wr = 0; resume_wdata = 0;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    // R1 reset state
    chk(sof_en, 1, "R1", "sof_en after reset");
    chk(wake_irq | resume_bit | suspended, 0, "R1", "flags after reset");

    // R9 K while active does nothing
    line_k = 1; tick(WAKE + 4); line_k = 0; tick(1);
    chk(wake_irq, 0, "R9", "irq after K while active");

    // R6 resume write while active ignored
    write_resume(1); tick(1);
    chk(resume_bit, 0, "R6", "resume write while active");

    // R2 suspend
    pulse_suspend();
    chk(suspended, 1, "R2", "suspended after request");
    pulse_suspend();
    chk(sof_en, 0, "R2", "second request ignored");

    // R3 short glitches (WAKE-1) ignored twice in a row
    line_k = 1; tick(WAKE - 1); line_k = 0; tick(1);
    line_k = 1; tick(WAKE - 1); line_k = 0; tick(2);
    chk(wake_irq, 0, "R3", "short K runs ignored");

    // R3 exact threshold
    line_k = 1; tick(WAKE); line_k = 0;
    chk(wake_irq, 1, "R3", "irq at threshold");
    chk(resume_bit, 1, "R3", "resume self-set");

    // R5 write zero leaves flag, write one clears
    wake_wr = 1; wake_wdata = 0; tick(1); wake_wr = 0;
    chk(wake_irq, 1, "R5", "write zero no effect");
    wake_wr = 1; wake_wdata = 1; tick(1); wake_wr = 0; wake_wdata = 0;
    chk(wake_irq, 0, "R5", "write one clears");

    // R4 resume held, suspend request ignored
    tick(5); pulse_suspend();
    chk(drive_k, 1, "R4", "K driven during resume");

    // R7 end resume
    write_resume(0);
    chk(drive_eor, 1, "R7", "eor begins");
    tick(EOR - 1);
    chk(drive_eor, 1, "R7", "eor last cycle");
    tick(1);
    chk(drive_idle, 1, "R7", "idle after eor");
    write_resume(1);
    chk(sof_en, 1, "R7", "sof after idle, resume write ignored");
    chk(resume_bit, 0, "R6", "write one in idle ignored");

    // R6 host-initiated resume
    tick(2); pulse_suspend(); tick(3);
    write_resume(1);
    chk(resume_bit, 1, "R6", "host resume sets bit");
    chk(wake_irq, 0, "R6", "no irq on host resume");
    tick(4); write_resume(0); tick(EOR + 1);
    chk(sof_en, 1, "R7", "sof after host resume");

    // R5 clear on the detection edge: set wins
    tick(2); pulse_suspend();
    line_k = 1; tick(WAKE - 1);
    wake_wr = 1; wake_wdata = 1; tick(1); wake_wr = 0; wake_wdata = 0; line_k = 0;
    chk(wake_irq, 1, "R5", "set wins over clear");
    tick(3); write_resume(0); tick(EOR + 3);
    chk(sof_en, 1, "R8", "port active at end");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule